// File: doc/BRIEF.md
# SD Host Advanced DMA Descriptor Chain Engine

This block walks the descriptor chain of an SD host controller's scatter-gather DMA. When it is started, it either builds one synthetic descriptor from a flat buffer address or reads descriptors from memory, starting at a chain base address. Memory is read through a simple request/valid port, one 32-bit word at a time. Two descriptor layouts are understood. The short layout is one word with an implied length. The long layout is two words with an explicit 16-bit length.

Nop, set-length, transfer and link operations are carried out along the chain. For every piece of data to be moved, the engine hands an address and a byte count to an external byte mover over a request/done handshake. It keeps track of how much of the whole transfer (block count times block size) is still outstanding. The run ends in one of two ways. On normal completion the engine writes zero back as the block count. When the chain runs out or is broken, it stops with an error and writes back the number of whole blocks still owed.

Top module: `adma_chain_walker`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `chunk_req`, `done`, `err` and `blk_count_wr` are low, and `err_code` is 0. While idle, no memory read and no chunk request is issued.
- R2: With `mode_sel` = 0, no memory is read. One descriptor is implied: valid, end, transfer, at `sdma_addr`, with a length of `blk_count` times `blk_size`. It is moved as consecutive chunks from that address.
- R3: With `mode_sel` = 2 or 3 (long layout), each descriptor is read as two words, at the pointer and at pointer+4. Word 0 holds the attributes in bits 5:0 and the length in bits 31:16. Word 1 holds the address. Attribute bit 0 is valid, bit 1 is end, bit 2 (interrupt) is ignored. Bits 5:4 hold the operation: 0 nop, 1 set, 2 transfer, 3 link.
- R4: With `mode_sel` = 1 (short layout), each descriptor is one word. Its address is the word's bits 31:12 with the low 12 bits zero, and its attributes are bits 5:0. Its length is the implied length, which is 4096 at every start.
- R5: A set operation replaces the implied length with bits 27:12 of the descriptor address. Later short-layout transfer descriptors use the new value.
- R6: A length of zero, whether explicit or implied, means 65536 bytes.
- R7: A link operation loads the descriptor pointer from the descriptor address. Any other operation advances the pointer by 8 (long layout) or 4 (short layout). The next descriptor is then read at the new pointer.
- R8: Each chunk is the smallest of three values: the block size, the bytes left in the current descriptor, and the bytes left in the whole transfer. Its length is never zero. The descriptor address advances by the chunk length after each chunk.
- R9: If a new descriptor is needed (the current one is invalid, exhausted or not a transfer) while the current one is marked end or is invalid, the engine aborts. It pulses `err`, sets `err_code` to 1, and writes back the remaining bytes divided by the block size, rounded down, with `blk_count_wr`.
- R10: When the remaining transfer size reaches zero, the engine pulses `done`, writes back a block count of 0, and goes idle without further reads. A zero total completes without any chunk.
- R11: `start` is ignored while `busy` is high. An accepted start clears `err_code` to 0.
- R12: `mem_req` holds `mem_addr` steady until `mem_valid` is seen. `chunk_req` holds `chunk_addr` and `chunk_len` steady until `chunk_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| mode_sel | input | 2 | 0 flat buffer, 1 short layout, 2/3 long layout |
| blk_size | input | BSZ_W | Block size in bytes |
| blk_count | input | BCNT_W | Number of blocks |
| sdma_addr | input | 32 | Flat buffer address for mode 0 |
| chain_base | input | 32 | Address of the first descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| chunk_req | output | 1 | Chunk move request |
| chunk_addr | output | 32 | Chunk start address |
| chunk_len | output | BSZ_W | Chunk length in bytes |
| chunk_done | input | 1 | Chunk move finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| err | output | 1 | One-cycle pulse on abort |
| err_code | output | 2 | 1 after an abort, cleared on start |
| blk_count_out | output | BCNT_W | Block count written back |
| blk_count_wr | output | 1 | Strobe for blk_count_out |

## Verification
A start is registered at the next rising edge, so `busy` and the cleared `err_code` are due one cycle after `start`. A word is taken at the edge where `mem_valid` is high, and the next read address or chunk request appears one cycle after that. `done`, `err` and the written-back count follow one cycle after the deciding evaluation. The bench's memory and byte-mover models act and sample on the falling edge, where every registered output has settled. They hold each request for a fixed wait before answering, and pop the expected read address or chunk from scoreboard queues at the moment of acceptance. Each run's ending kind and written-back count are compared once the `done` or `err` pulse has been seen.

// File: rtl/adma_walk_pkg.sv
package adma_walk_pkg;

  localparam int AW = 32;
  localparam logic [15:0] IMPLIED_RESET = 16'h1000;

  // attribute bit positions
  localparam int ATTR_VALID = 0;
  localparam int ATTR_END   = 1;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_SET  = 2'd1,
    OP_XFER = 2'd2,
    OP_LINK = 2'd3
  } desc_op_e;

  typedef struct packed {
    logic [5:0]    attr;
    logic [15:0]   len_raw;
    logic [AW-1:0] addr;
  } desc_t;

  // zero length field encodes 65536 bytes
  function automatic logic [16:0] len_expand(input logic [15:0] raw);
    return (raw == 16'd0) ? 17'h10000 : {1'b0, raw};
  endfunction

  function automatic desc_op_e attr_op(input logic [5:0] attr);
    return desc_op_e'(attr[5:4]);
  endfunction

  function automatic logic [AW-1:0] ptr_advance(input logic [AW-1:0] p, input logic wide);
    return p + (wide ? 32'd8 : 32'd4);
  endfunction

endpackage

// File: rtl/adma_desc_fetch.sv
module adma_desc_fetch
  import adma_walk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wide,
  input  logic [AW-1:0] ptr,
  input  logic [15:0]   implied,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  output logic          fetched,
  output desc_t         desc
);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fetch_st_e;

  fetch_st_e     st;
  logic [AW-1:0] base_q;
  logic          wide_q;
  logic [15:0]   impl_q;

  assign mem_req  = (st != F_IDLE);
  assign mem_addr = (st == F_HI) ? base_q + 32'd4 : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      base_q  <= '0;
      wide_q  <= 1'b0;
      impl_q  <= '0;
      fetched <= 1'b0;
      desc    <= '0;
    end else begin
      fetched <= 1'b0;
      case (st)
        F_IDLE: begin
          if (go) begin
            base_q <= ptr;
            wide_q <= wide;
            impl_q <= implied;
            st     <= F_LO;
          end
        end
        F_LO: begin
          if (mem_valid) begin
            desc.attr <= mem_rdata[5:0];
            if (wide_q) begin
              desc.len_raw <= mem_rdata[31:16];
              st           <= F_HI;
            end else begin
              desc.addr    <= {mem_rdata[31:12], 12'h000};
              desc.len_raw <= impl_q;
              fetched      <= 1'b1;
              st           <= F_IDLE;
            end
          end
        end
        F_HI: begin
          if (mem_valid) begin
            desc.addr <= mem_rdata;
            fetched   <= 1'b1;
            st        <= F_IDLE;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adma_byte_budget.sv
module adma_byte_budget #(
  parameter int BCNT_W = 16,
  parameter int BSZ_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BCNT_W-1:0] load_blocks,
  input  logic [BSZ_W-1:0]  load_size,
  input  logic              step,
  input  logic [BSZ_W-1:0]  step_len,
  input  logic [BSZ_W-1:0]  bsz,
  output logic [BCNT_W-1:0] blk_left,
  output logic [BSZ_W-1:0]  part,
  output logic              empty
);

  localparam int PW = BSZ_W + 1;

  // remaining bytes = blk_left * bsz + part, with part < bsz
  function automatic logic [BCNT_W+BSZ_W-1:0] take(
    input logic [BCNT_W-1:0] b,
    input logic [BSZ_W-1:0]  p,
    input logic [BSZ_W-1:0]  s,
    input logic [BSZ_W-1:0]  c
  );
    logic [PW-1:0] wide_p;
    if (c <= p) begin
      return {b, p - c};
    end
    wide_p = {1'b0, p} + {1'b0, s} - {1'b0, c};
    return {b - 1'b1, wide_p[BSZ_W-1:0]};
  endfunction

  assign empty = (blk_left == '0) && (part == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_left <= '0;
      part     <= '0;
    end else if (load) begin
      blk_left <= (load_size == '0) ? '0 : load_blocks;
      part     <= '0;
    end else if (step) begin
      {blk_left, part} <= take(blk_left, part, bsz, step_len);
    end
  end

endmodule

// File: rtl/adma_chain_walker.sv
module adma_chain_walker
  import adma_walk_pkg::*;
#(
  parameter int BCNT_W = 16,
  parameter int BSZ_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode_sel,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [BCNT_W-1:0] blk_count,
  input  logic [31:0]       sdma_addr,
  input  logic [31:0]       chain_base,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata,
  output logic              chunk_req,
  output logic [31:0]       chunk_addr,
  output logic [BSZ_W-1:0]  chunk_len,
  input  logic              chunk_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic [BCNT_W-1:0] blk_count_out,
  output logic              blk_count_wr
);

  localparam int REM_W = (BCNT_W + BSZ_W > 17) ? BCNT_W + BSZ_W : 17;
  localparam logic [5:0] FLAT_ATTR = 6'h23; // transfer, end, valid

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EVAL, S_MOVE} walk_st_e;

  function automatic logic [REM_W-1:0] flat_span(
    input logic [BCNT_W-1:0] cnt,
    input logic [BSZ_W-1:0]  bs
  );
    return REM_W'(cnt) * REM_W'(bs);
  endfunction

  function automatic logic [BSZ_W-1:0] pick_chunk(
    input logic [BSZ_W-1:0] bs,
    input logic [REM_W-1:0] rem,
    input logic             last_blk,
    input logic [BSZ_W-1:0] tail
  );
    logic [BSZ_W-1:0] c;
    c = bs;
    if (rem < REM_W'(bs)) c = rem[BSZ_W-1:0];
    if (last_blk && (tail < c)) c = tail;
    return c;
  endfunction

  walk_st_e          st;
  logic [1:0]        mode_q;
  logic [BSZ_W-1:0]  bsz_q;
  logic [5:0]        cur_attr;
  logic [31:0]       cur_addr;
  logic [REM_W-1:0]  cur_rem;
  logic [31:0]       ptr_q;
  logic [15:0]       impl_q;
  logic [BSZ_W-1:0]  chunk_len_q;

  logic              wide;
  desc_op_e          cur_op;
  logic              cur_valid, cur_end, need_next;
  logic              ev_start, ev_finish, ev_abort, ev_next, ev_move, ev_moved;
  logic [31:0]       next_ptr;
  logic [15:0]       next_impl;
  logic              fetch_go, go_wide;
  logic [31:0]       go_ptr;
  logic [15:0]       go_impl;
  logic              fetched;
  desc_t             fdesc;
  logic [BCNT_W-1:0] bud_blk;
  logic [BSZ_W-1:0]  bud_part;
  logic              bud_empty;

  assign wide      = mode_q[1];
  assign cur_op    = attr_op(cur_attr);
  assign cur_valid = cur_attr[ATTR_VALID];
  assign cur_end   = cur_attr[ATTR_END];
  assign need_next = !cur_valid || (cur_rem == '0) || (cur_op != OP_XFER);

  assign ev_start  = (st == S_IDLE) && start;
  assign ev_finish = (st == S_EVAL) && bud_empty;
  assign ev_abort  = (st == S_EVAL) && !bud_empty && need_next && (cur_end || !cur_valid);
  assign ev_next   = (st == S_EVAL) && !bud_empty && need_next && !(cur_end || !cur_valid);
  assign ev_move   = (st == S_EVAL) && !bud_empty && !need_next;
  assign ev_moved  = (st == S_MOVE) && chunk_done;

  assign next_ptr  = (cur_op == OP_LINK) ? cur_addr : ptr_advance(ptr_q, wide);
  assign next_impl = (cur_op == OP_SET) ? cur_addr[27:12] : impl_q;

  assign fetch_go  = ev_next || (ev_start && (mode_sel != 2'd0));
  assign go_ptr    = (st == S_IDLE) ? chain_base    : next_ptr;
  assign go_impl   = (st == S_IDLE) ? IMPLIED_RESET : next_impl;
  assign go_wide   = (st == S_IDLE) ? mode_sel[1]   : wide;

  assign busy       = (st != S_IDLE);
  assign chunk_req  = (st == S_MOVE);
  assign chunk_addr = cur_addr;
  assign chunk_len  = chunk_len_q;

  adma_desc_fetch i_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (fetch_go),
    .wide      (go_wide),
    .ptr       (go_ptr),
    .implied   (go_impl),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .fetched   (fetched),
    .desc      (fdesc)
  );

  adma_byte_budget #(
    .BCNT_W (BCNT_W),
    .BSZ_W  (BSZ_W)
  ) i_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ev_start),
    .load_blocks (blk_count),
    .load_size   (blk_size),
    .step        (ev_moved),
    .step_len    (chunk_len_q),
    .bsz         (bsz_q),
    .blk_left    (bud_blk),
    .part        (bud_part),
    .empty       (bud_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      mode_q        <= '0;
      bsz_q         <= '0;
      cur_attr      <= '0;
      cur_addr      <= '0;
      cur_rem       <= '0;
      ptr_q         <= '0;
      impl_q        <= IMPLIED_RESET;
      chunk_len_q   <= '0;
      done          <= 1'b0;
      err           <= 1'b0;
      err_code      <= 2'd0;
      blk_count_out <= '0;
      blk_count_wr  <= 1'b0;
    end else begin
      done         <= 1'b0;
      err          <= 1'b0;
      blk_count_wr <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            mode_q   <= mode_sel;
            bsz_q    <= blk_size;
            err_code <= 2'd0;
            ptr_q    <= chain_base;
            impl_q   <= IMPLIED_RESET;
            if (mode_sel == 2'd0) begin
              cur_attr <= FLAT_ATTR;
              cur_addr <= sdma_addr;
              cur_rem  <= flat_span(blk_count, blk_size);
              st       <= S_EVAL;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (fetched) begin
            cur_attr <= fdesc.attr;
            cur_addr <= fdesc.addr;
            cur_rem  <= REM_W'(len_expand(fdesc.len_raw));
            st       <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (ev_finish) begin
            done          <= 1'b1;
            blk_count_out <= '0;
            blk_count_wr  <= 1'b1;
            st            <= S_IDLE;
          end else if (ev_abort) begin
            err           <= 1'b1;
            err_code      <= 2'd1;
            blk_count_out <= bud_blk;
            blk_count_wr  <= 1'b1;
            st            <= S_IDLE;
          end else if (ev_next) begin
            ptr_q  <= next_ptr;
            impl_q <= next_impl;
            st     <= S_FETCH;
          end else begin
            chunk_len_q <= pick_chunk(bsz_q, cur_rem, bud_blk == '0, bud_part);
            st          <= S_MOVE;
          end
        end
        S_MOVE: begin
          if (chunk_done) begin
            cur_addr <= cur_addr + 32'(chunk_len_q);
            cur_rem  <= cur_rem - REM_W'(chunk_len_q);
            st       <= S_EVAL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adma_walker_chk.sv
module adma_walker_chk #(
  parameter int BCNT_W = 16,
  parameter int BSZ_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [1:0]        err_code,
  input logic [BCNT_W-1:0] blk_count_out,
  input logic              blk_count_wr,
  input logic              mem_req,
  input logic [31:0]       mem_addr,
  input logic              mem_valid,
  input logic              chunk_req,
  input logic [31:0]       chunk_addr,
  input logic [BSZ_W-1:0]  chunk_len,
  input logic              chunk_done,
  input logic              ev_finish,
  input logic              ev_abort
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R12
  chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_req && !chunk_done |=> chunk_req && $stable(chunk_addr) && $stable(chunk_len));

  // R8
  chunk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_req |-> chunk_len != '0);

  // R10
  finish_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done && blk_count_wr && (blk_count_out == '0) && !busy);

  // R9
  abort_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> err && blk_count_wr && (err_code == 2'd1) && !busy);

  // R10
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !chunk_req);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || err);

endmodule

bind adma_chain_walker adma_walker_chk #(
  .BCNT_W (BCNT_W),
  .BSZ_W  (BSZ_W)
) i_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .err           (err),
  .err_code      (err_code),
  .blk_count_out (blk_count_out),
  .blk_count_wr  (blk_count_wr),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_valid     (mem_valid),
  .chunk_req     (chunk_req),
  .chunk_addr    (chunk_addr),
  .chunk_len     (chunk_len),
  .chunk_done    (chunk_done),
  .ev_finish     (ev_finish),
  .ev_abort      (ev_abort)
);

// File: tb/test_adma_chain_walker.sv
module test_adma_chain_walker;
  localparam int BCNT_W = 16;
  localparam int BSZ_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        mode_sel = 2'd0;
  logic [BSZ_W-1:0]  blk_size = '0;
  logic [BCNT_W-1:0] blk_count = '0;
  logic [31:0]       sdma_addr = '0;
  logic [31:0]       chain_base = '0;
  logic              mem_req;
  logic [31:0]       mem_addr;
  logic              mem_valid = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic              chunk_req;
  logic [31:0]       chunk_addr;
  logic [BSZ_W-1:0]  chunk_len;
  logic              chunk_done = 1'b0;
  logic              busy, done, err;
  logic [1:0]        err_code;
  logic [BCNT_W-1:0] blk_count_out;
  logic              blk_count_wr;

  int checks = 0;
  int errors = 0;
  logic [31:0] memw [int];
  logic [31:0] exp_rd [$];
  logic [43:0] exp_ck [$];
  int          end_cnt = 0;
  logic        end_err = 1'b0;
  logic [BCNT_W-1:0] end_count = '0;
  int          mem_wait = 0;
  int          ck_wait = 0;
  logic [31:0] held_addr = '0;

  always #10 clk = ~clk;

  adma_chain_walker #(.BCNT_W(BCNT_W), .BSZ_W(BSZ_W)) i_adma_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .blk_size(blk_size), .blk_count(blk_count), .sdma_addr(sdma_addr),
    .chain_base(chain_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .chunk_req(chunk_req),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len), .chunk_done(chunk_done),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .blk_count_out(blk_count_out), .blk_count_wr(blk_count_wr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_rd(input logic [31:0] a);
    exp_rd.push_back(a);
  endtask

  task automatic push_ck(input logic [31:0] a, input int len);
    exp_ck.push_back({a, BSZ_W'(len)});
  endtask

  // memory model: answers after a fixed wait, scoreboard on read addresses
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
      mem_wait  <= 0;
    end else if (mem_req) begin
      if (mem_wait == 0) held_addr <= mem_addr;
      else if (mem_addr != held_addr) check(0, "R12", "read address moved", mem_addr, held_addr);
      if (mem_wait == 2) begin
        mem_valid <= 1'b1;
        mem_rdata <= memw.exists(int'(mem_addr)) ? memw[int'(mem_addr)] : 32'h0;
        if (exp_rd.size() == 0) begin
          check(0, "R7", "unexpected read", mem_addr, 0);
        end else begin
          check(mem_addr == exp_rd[0], "R3/R4/R7", "read address", mem_addr, exp_rd[0]);
          void'(exp_rd.pop_front());
        end
        mem_wait <= 0;
      end else begin
        mem_wait <= mem_wait + 1;
      end
    end
  end

  // byte mover model: scoreboard on chunks
  always @(negedge clk) begin
    if (chunk_done) begin
      chunk_done <= 1'b0;
      ck_wait    <= 0;
    end else if (chunk_req) begin
      if (ck_wait == 1) begin
        chunk_done <= 1'b1;
        if (exp_ck.size() == 0) begin
          check(0, "R8", "unexpected chunk", {chunk_addr, chunk_len}, 0);
        end else begin
          check({chunk_addr, chunk_len} == exp_ck[0], "R2/R8", "chunk addr,len",
                {chunk_addr, chunk_len}, exp_ck[0]);
          void'(exp_ck.pop_front());
        end
        ck_wait <= 0;
      end else begin
        ck_wait <= ck_wait + 1;
      end
    end
  end

  // end-of-run monitor
  always @(negedge clk) begin
    if (done || err) begin
      end_cnt   = end_cnt + 1;
      end_err   = err;
      end_count = blk_count_out;
      check(blk_count_wr, "R9/R10", "count write strobe", blk_count_wr, 1);
    end
  end

  task automatic run_job(input logic [1:0] m, input int bs, input int cnt,
                         input logic [31:0] sa, input logic [31:0] cb,
                         input bit exp_err, input int exp_cnt, input bit poke,
                         input string tag);
    int n;
    n = end_cnt;
    @(negedge clk);
    mode_sel = m; blk_size = BSZ_W'(bs); blk_count = BCNT_W'(cnt);
    sdma_addr = sa; chain_base = cb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    check(err_code == 2'd0, "R11", "error code cleared at start", err_code, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      // R11: a second start while busy must not disturb the run
      mode_sel = 2'd1; chain_base = 32'h900; blk_count = 16'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 5000 && end_cnt == n; w++) @(negedge clk);
    check(end_cnt == n + 1, tag, "run ended once", end_cnt - n, 1);
    check(end_err == exp_err, tag, "abort flag", end_err, exp_err);
    check(end_count == BCNT_W'(exp_cnt), tag, "written-back count", end_count, exp_cnt);
    if (exp_err) check(err_code == 2'd1, "R9", "error code", err_code, 1);
    check(exp_ck.size() == 0, tag, "chunks outstanding", exp_ck.size(), 0);
    check(exp_rd.size() == 0, tag, "reads outstanding", exp_rd.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // long layout chain: transfer, nop, link, transfer with zero length
    memw[32'h100] = 32'h0300_0021; memw[32'h104] = 32'h0000_8000;
    memw[32'h108] = 32'h0000_0001; memw[32'h10C] = 32'h0000_0000;
    memw[32'h110] = 32'h0000_0031; memw[32'h114] = 32'h0000_0200;
    memw[32'h200] = 32'h0000_0023; memw[32'h204] = 32'h0000_A000;
    // short layout: set length 64, then transfer+end
    memw[32'h300] = 32'h0004_0011; memw[32'h304] = 32'h0005_0023;
    // short layout default length
    memw[32'h380] = 32'h0000_7023;
    // long layout, 25 bytes then end
    memw[32'h400] = 32'h0019_0023; memw[32'h404] = 32'h0000_C000;
    // long layout invalid descriptor
    memw[32'h3C0] = 32'h0000_0000; memw[32'h3C4] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy in reset", busy, 0);
    check(!mem_req && !chunk_req, "R1", "requests in reset", {mem_req, chunk_req}, 0);
    check(!done && !err && !blk_count_wr, "R1", "pulses in reset", {done, err, blk_count_wr}, 0);
    check(err_code == 2'd0, "R1", "error code in reset", err_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !chunk_req, "R1", "idle quiet", {mem_req, chunk_req}, 0);

    // R2 flat buffer, with an ignored start while busy (R11)
    push_ck(32'h1000, 512); push_ck(32'h1200, 512); push_ck(32'h1400, 512);
    run_job(2'd0, 512, 3, 32'h1000, 32'h0, 1'b0, 0, 1'b1, "R2");

    // R3 R6 R7 R8 R10 long layout chain with nop and link
    push_rd(32'h100); push_rd(32'h104); push_rd(32'h108); push_rd(32'h10C);
    push_rd(32'h110); push_rd(32'h114); push_rd(32'h200); push_rd(32'h204);
    push_ck(32'h8000, 512); push_ck(32'h8200, 256);
    push_ck(32'hA000, 512); push_ck(32'hA200, 256);
    run_job(2'd2, 512, 3, 32'h0, 32'h100, 1'b0, 0, 1'b0, "R7");

    // R4 R5 R9 short layout with set-length, chain ends early
    push_rd(32'h300); push_rd(32'h304);
    push_ck(32'h5_0000, 32); push_ck(32'h5_0020, 32);
    run_job(2'd1, 32, 4, 32'h0, 32'h300, 1'b1, 2, 1'b0, "R5");

    // R4 R11 default implied length, err_code cleared after previous abort
    push_rd(32'h380);
    push_ck(32'h7000, 2048); push_ck(32'h7800, 2048);
    run_job(2'd1, 2048, 2, 32'h0, 32'h380, 1'b0, 0, 1'b0, "R4");

    // R8 R9 partial final chunk, floor of remaining blocks
    push_rd(32'h400); push_rd(32'h404);
    push_ck(32'hC000, 10); push_ck(32'hC00A, 10); push_ck(32'hC014, 5);
    run_job(2'd3, 10, 5, 32'h0, 32'h400, 1'b1, 2, 1'b0, "R9");

    // R9 invalid first descriptor, nothing moved
    push_rd(32'h3C0); push_rd(32'h3C4);
    run_job(2'd2, 10, 5, 32'h0, 32'h3C0, 1'b1, 5, 1'b0, "R9");

    // R10 zero total completes without any chunk
    run_job(2'd0, 512, 0, 32'h2000, 32'h0, 1'b0, 0, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule